// File: doc/BRIEF.md
# Re-Reference Interval Victim Selector

This block keeps the replacement state for one set of an N-way set-associative cache and chooses the way to evict when a line must be replaced. Each way holds a small saturating prediction value. The value estimates how soon the line will be used again: zero means soon, and the all-ones maximum means far in the future. A hit on a way sets its value to zero. A newly filled line starts one step below the maximum. A line that is not reused soon is therefore evicted before older lines that have been reused, which keeps a long streaming scan from flushing the reused part of the set.

The cache controller reports hits and fills with a way index. To get a victim, it holds a victim request until the block answers with a valid way. If no way is at the maximum, the block raises every value in the set by one on each cycle until at least one way reaches the maximum. It then returns the lowest-numbered such way. Tag comparison and data movement are done outside the block. With 1-bit values the same rules give not-recently-used replacement.

Top module: `rrip_victim_sel`

## Requirements
- R1: After reset, every way holds the maximum value (3 for the default 2-bit width). A victim request in the first cycle is answered in the same cycle with way 0.
- R2: A hit on a way sets its value to 0. Ways that still hold the maximum are chosen before that way.
- R3: A fill on a way sets its value to the maximum minus one (2 for the default width). This holds whatever the way held before.
- R4: vic_valid is high only in a cycle where vic_req is high and at least one way holds the maximum. vic_way then gives the lowest-numbered way that holds the maximum, and it is combinational from that cycle's inputs.
- R5: In each cycle where vic_req is high and no way holds the maximum, every value rises by one at the clock edge and vic_valid stays low. When all values start at 0, the answer comes after 3 low cycles.
- R6: A hit in the same cycle as a victim request is applied first. The hit way counts as 0 in that cycle's search. If the search then finds no maximum, the hit way is aged from 0 to 1 with the rest of the set.
- R7: While vic_req is low, no value ages, however many cycles pass.
- R8: A fill and a hit on the same way in the same cycle leave that way at the fill value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_valid | input | 1 | A hit occurred on hit_way this cycle |
| hit_way | input | $clog2(WAYS) | Way that hit |
| fill_valid | input | 1 | A new line is written into fill_way this cycle |
| fill_way | input | $clog2(WAYS) | Way being filled |
| vic_req | input | 1 | Victim request, held until vic_valid |
| vic_valid | output | 1 | vic_way holds the chosen victim this cycle |
| vic_way | output | $clog2(WAYS) | Chosen victim way |

## Verification
The per-way values are never visible directly. A wrong value shows up at the ports in two ways: as the wrong victim index, or as the wrong number of low vic_valid cycles before the answer, since the wait is exactly the maximum minus the largest value in the set. Each scenario builds a known value pattern through hits and fills, then requests a victim. A corrupted value, a missed clear or fill, a wrong insertion value, or aging while idle is seen at the next request as a wrong index or a wait that is off by one or more cycles. Same-cycle hit-and-request and fill-and-hit cases are chosen so that the wrong ordering changes the answer on the very next request.

// File: rtl/rrip_pkg.sv
package rrip_pkg;

    localparam int unsigned RRIP_DEF_WAYS = 8;
    localparam int unsigned RRIP_DEF_CW   = 2;

    // per-way update kind for one cycle, fill outranks hit
    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_CLEAR = 2'd1,
        UPD_LOAD  = 2'd2
    } upd_e;

    function automatic upd_e rrip_decode(input logic is_fill, input logic is_hit);
        if (is_fill)     return UPD_LOAD;
        else if (is_hit) return UPD_CLEAR;
        else             return UPD_HOLD;
    endfunction

endpackage

// File: rtl/rrip_way_ctr.sv
module rrip_way_ctr
    import rrip_pkg::*;
#(
    parameter int unsigned CW = RRIP_DEF_CW
) (
    input  logic          clk,
    input  logic          rst,
    input  upd_e          upd_i,
    input  logic          age_i,
    output logic [CW-1:0] eff_o
);

    localparam logic [CW-1:0] MAXV = '1;
    localparam logic [CW-1:0] INSV = MAXV - CW'(1);

    logic [CW-1:0] q;
    logic [CW-1:0] d;

    // value seen by this cycle's search: a hit applies first
    assign eff_o = (upd_i == UPD_CLEAR) ? '0 : q;

    always_comb begin
        if (upd_i == UPD_LOAD) d = INSV;
        else if (age_i)        d = eff_o + CW'(1);
        else                   d = eff_o;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= MAXV;
        else     q <= d;
    end

    // R3
    fill_value_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i == UPD_LOAD) |=> (q == INSV));

    // R2
    hit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i == UPD_CLEAR && !age_i) |=> (q == '0));

    // R5
    age_step_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i == UPD_HOLD && age_i) |=> (q == $past(q) + CW'(1)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_i == UPD_HOLD && !age_i) |=> $stable(q));

endmodule

// File: rtl/rrip_pick.sv
module rrip_pick #(
    parameter int unsigned WAYS  = 8,
    parameter int unsigned CW    = 2,
    localparam int unsigned IDX_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0][CW-1:0] vals_i,
    output logic                    found_o,
    output logic [IDX_W-1:0]        idx_o
);

    localparam logic [CW-1:0] MAXV = '1;

    // scan downward so the lowest qualifying way is the last written
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (vals_i[i] == MAXV) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rrip_victim_sel.sv
module rrip_victim_sel
    import rrip_pkg::*;
#(
    parameter int unsigned WAYS  = RRIP_DEF_WAYS,
    parameter int unsigned CW    = RRIP_DEF_CW,
    localparam int unsigned IDX_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hit_valid,
    input  logic [IDX_W-1:0] hit_way,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_way,
    input  logic             vic_req,
    output logic             vic_valid,
    output logic [IDX_W-1:0] vic_way
);

    localparam logic [CW-1:0] MAXV = '1;

    logic [WAYS-1:0][CW-1:0] eff;
    logic                    any_max;
    logic                    age;

    // age the whole set only when a request finds no maximum
    assign age       = vic_req & ~any_max;
    assign vic_valid = vic_req & any_max;

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        upd_e upd;
        assign upd = rrip_decode(fill_valid && (fill_way == IDX_W'(g)),
                                 hit_valid  && (hit_way  == IDX_W'(g)));
        rrip_way_ctr #(.CW(CW)) i_ctr (
            .clk   (clk),
            .rst   (rst),
            .upd_i (upd),
            .age_i (age),
            .eff_o (eff[g])
        );
    end

    rrip_pick #(.WAYS(WAYS), .CW(CW)) i_pick (
        .vals_i  (eff),
        .found_o (any_max),
        .idx_o   (vic_way)
    );

    // R4
    valid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> vic_req);

    // R4
    victim_at_max_chk: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> (eff[vic_way] == MAXV));

endmodule

// File: tb/test_rrip_victim_sel.sv
`timescale 1ns/1ps
module test_rrip_victim_sel;

    localparam int WAYS = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hit_valid = 1'b0;
    logic [2:0] hit_way = '0;
    logic       fill_valid = 1'b0;
    logic [2:0] fill_way = '0;
    logic       vic_req = 1'b0;
    logic       vic_valid;
    logic [2:0] vic_way;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    rrip_victim_sel #(.WAYS(WAYS), .CW(2)) i_rrip_victim_sel (
        .clk        (clk),
        .rst        (rst),
        .hit_valid  (hit_valid),
        .hit_way    (hit_way),
        .fill_valid (fill_valid),
        .fill_way   (fill_way),
        .vic_req    (vic_req),
        .vic_valid  (vic_valid),
        .vic_way    (vic_way)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_hit(input int w);
        hit_valid = 1'b1; hit_way = 3'(w);
        @(negedge clk);
        hit_valid = 1'b0;
    endtask

    task automatic do_fill(input int w);
        fill_valid = 1'b1; fill_way = 3'(w);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hold a request, count low-valid cycles, compare way and wait
    task automatic request(input int exp_way, input int exp_wait, input string tag);
        int waited = 0;
        vic_req = 1'b1;
        #1;
        while (!vic_valid && waited < 10) begin
            @(negedge clk);
            waited++;
            #1;
        end
        check({tag, " wait"}, waited, exp_wait);
        check({tag, " way"}, int'(vic_way), exp_way);
        @(negedge clk);
        vic_req = 1'b0;
    endtask

    task automatic t_reset;
        #1;
        check("R4 no valid without request", int'(vic_valid), 0);
        request(0, 0, "R1 reset state");
    endtask

    task automatic t_fill_value;
        for (int w = 0; w < WAYS; w++) do_fill(w);
        request(0, 1, "R3 fill inserts max-1");
    endtask

    task automatic t_hit_clear;
        for (int w = 0; w < 3; w++) do_hit(w);
        request(3, 0, "R2 hit ways skipped");
        for (int w = 3; w < WAYS; w++) do_fill(w);
        do_hit(4);
        request(3, 1, "R2 mixed set");
        do_hit(3);
        request(5, 0, "R4 lowest of several max");
    endtask

    task automatic t_aging;
        for (int w = 0; w < WAYS; w++) do_hit(w);
        request(0, 3, "R5 age from zero");
    endtask

    task automatic t_idle;
        for (int w = 0; w < WAYS; w++) do_fill(w);
        idle(6);
        #1;
        check("R4 idle valid low", int'(vic_valid), 0);
        @(negedge clk);
        request(0, 1, "R7 no aging while idle");
    endtask

    task automatic t_hit_with_req;
        vic_req = 1'b1; hit_valid = 1'b1; hit_way = 3'd0;
        #1;
        check("R6 same-cycle hit valid", int'(vic_valid), 1);
        check("R6 same-cycle hit way", int'(vic_way), 1);
        @(negedge clk);
        vic_req = 1'b0; hit_valid = 1'b0;
        for (int w = 1; w < 7; w++) do_hit(w);
        vic_req = 1'b1; hit_valid = 1'b1; hit_way = 3'd7;
        #1;
        check("R6 hit removes only max", int'(vic_valid), 0);
        @(negedge clk);
        hit_valid = 1'b0;
        request(0, 2, "R6 hit way aged with set");
    endtask

    task automatic t_fill_over_hit;
        for (int w = 0; w < WAYS; w++) if (w != 2) do_hit(w);
        fill_valid = 1'b1; fill_way = 3'd2;
        hit_valid = 1'b1;  hit_way = 3'd2;
        @(negedge clk);
        fill_valid = 1'b0; hit_valid = 1'b0;
        request(2, 1, "R8 fill beats hit");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fill_value();
        t_hit_clear();
        t_aging();
        t_idle();
        t_hit_with_req();
        t_fill_over_hit();
        idle(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule